// File: doc/BRIEF.md
# AHB-Lite Stall-Safe Bus Manager

This block is the manager front end of an AHB-Lite port. A local requester hands it single read or write commands over a valid/ready interface. Each command carries an address, a transfer size, a direction flag and write data. The manager turns every command into a pipelined AHB-Lite transfer. The address phase of one transfer overlaps the data phase of the one before it, and the block returns one registered response per command.

All state that moves a transfer forward is enabled by the single HREADY input: the address-phase registers, the write-data register and the response/read-capture registers. A subordinate may stretch a data phase for any number of cycles. During that time every bus output stays frozen, and nothing is sampled. Read data, write acceptance and the transfer response are taken only in the completing cycle.

An error response cancels the transfer queued behind the failing one. The cancelled command is still reported to the requester, with an error flag, so the requester sees every command it issued answered in order.

Top module: `ahb_stall_mgr`

## Requirements
- R1: While rst_ni is low, HTRANS is IDLE (2'b00) and rsp_valid_o is 0.
- R2: req_ready_o equals hready_i. A command accepted at a clock edge (req_valid_i and req_ready_o both high) is presented in the next cycle with HTRANS NONSEQ (2'b10) and its own address, direction and size. After an edge with hready_i high and no accepted command, HTRANS is IDLE. HBURST is always SINGLE (3'b000) and HPROT equals the parameter PROT (default 4'b0011).
- R3: While hready_i is low and hresp_i is low, HADDR, HTRANS, HWRITE and HSIZE keep their values into the next cycle.
- R4: HWDATA carries a write's data in that write's data phase, which is the cycle after its address phase is accepted. HWDATA does not change while hready_i is low.
- R5: For a read, rsp_rdata_o equals HRDATA as sampled in the data-phase cycle where hready_i is high. HRDATA values driven during wait cycles have no effect on it.
- R6: Every issued command gets exactly one response, in issue order. rsp_valid_o is high for one cycle, the cycle after the completing cycle. rsp_write_o gives the direction. Data phases of any length from 0 to 7 wait cycles complete without abort.
- R7: With a zero-wait subordinate, a transfer completes in its first data-phase cycle, and a new command may be accepted in every cycle, so address and data phases overlap back to back.
- R8: An error takes two cycles: hresp_i=1 with hready_i=0, then hresp_i=1 with hready_i=1. After the first of these cycles HTRANS is IDLE. The failing transfer responds with rsp_err_o=1. A command that was in its address phase during that first cycle is dropped from the bus and reported with rsp_err_o=1 in the cycle after the failing transfer's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command valid |
| req_ready_o | output | 1 | Command accepted when high with req_valid_i |
| req_addr_i | input | AW | Command address |
| req_size_i | input | 3 | Command transfer size (HSIZE encoding) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW | Command write data |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_err_o | output | 1 | Response carries an error |
| rsp_write_o | output | 1 | Response belongs to a write |
| rsp_rdata_o | output | DW | Captured read data |
| haddr_o | output | AW | Bus address |
| htrans_o | output | 2 | Bus transfer type |
| hwrite_o | output | 1 | Bus direction |
| hsize_o | output | 3 | Bus transfer size |
| hburst_o | output | 3 | Bus burst type, fixed SINGLE |
| hprot_o | output | 4 | Bus protection attributes |
| hwdata_o | output | DW | Bus write data |
| hready_i | input | 1 | Bus transfer-complete / advance |
| hresp_i | input | 1 | Bus error response |
| hrdata_i | input | DW | Bus read data |

## Verification
The assertions assume a subordinate that follows the protocol. It holds hready_i low only while a data phase is in progress. It raises hresp_i only as the two-cycle error sequence, with hready_i low in the first cycle and high in the second, and never while no data phase is active. The bench's subordinate model enforces this by construction: it derives hready_i and hresp_i from its own record of the active data phase, inserts 0 to 7 wait cycles from an arithmetic pattern, and injects errors only on data phases with no waits before them. During every wait it drives the bitwise inverse of the correct read data on HRDATA, so a capture taken at the wrong time shows up in the response.

// File: rtl/ahb_mgr_pkg.sv
package ahb_mgr_pkg;
  typedef enum logic [1:0] {
    HTRANS_IDLE   = 2'b00,
    HTRANS_BUSY   = 2'b01,
    HTRANS_NONSEQ = 2'b10,
    HTRANS_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] HBURST_SINGLE = 3'b000;
endpackage

// File: rtl/ahb_mgr_addr_stage.sv
module ahb_mgr_addr_stage #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hready_i,
  input  logic          cancel_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [2:0]    req_size_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic          ap_valid_o,
  output logic [AW-1:0] ap_addr_o,
  output logic [2:0]    ap_size_o,
  output logic          ap_write_o,
  output logic [DW-1:0] ap_wdata_o
);
  // address phase may only be replaced on an HREADY-high edge
  assign req_ready_o = hready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_valid_o <= 1'b0;
      ap_addr_o  <= '0;
      ap_size_o  <= '0;
      ap_write_o <= 1'b0;
      ap_wdata_o <= '0;
    end else if (hready_i) begin
      ap_valid_o <= req_valid_i;
      if (req_valid_i) begin
        ap_addr_o  <= req_addr_i;
        ap_size_o  <= req_size_i;
        ap_write_o <= req_write_i;
        ap_wdata_o <= req_wdata_i;
      end
    end else if (cancel_i) begin
      // first error cycle: drop queued transfer to IDLE
      ap_valid_o <= 1'b0;
    end
  end

  // R2
  accept_to_nonseq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (ap_valid_o && ap_addr_o == $past(req_addr_i)
                                      && ap_write_o == $past(req_write_i)));
endmodule

// File: rtl/ahb_mgr_data_stage.sv
module ahb_mgr_data_stage #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hready_i,
  input  logic          ap_valid_i,
  input  logic          ap_write_i,
  input  logic [DW-1:0] ap_wdata_i,
  output logic          dp_valid_o,
  output logic          dp_write_o,
  output logic [DW-1:0] hwdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_valid_o <= 1'b0;
      dp_write_o <= 1'b0;
      hwdata_o   <= '0;
    end else if (hready_i) begin
      dp_valid_o <= ap_valid_i;
      dp_write_o <= ap_write_i;
      if (ap_valid_i && ap_write_i) hwdata_o <= ap_wdata_i;
    end
  end

  // R4
  hwdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> $stable(hwdata_o));
endmodule

// File: rtl/ahb_mgr_resp_stage.sv
module ahb_mgr_resp_stage #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hready_i,
  input  logic          hresp_i,
  input  logic [DW-1:0] hrdata_i,
  input  logic          dp_valid_i,
  input  logic          dp_write_i,
  input  logic          cancel_i,
  input  logic          ap_valid_i,
  input  logic          ap_write_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic          rsp_write_o,
  output logic [DW-1:0] rsp_rdata_o
);
  logic done;
  logic kill_pend_q, kill_write_q;

  assign done = dp_valid_i && hready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_err_o    <= 1'b0;
      rsp_write_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      kill_pend_q  <= 1'b0;
      kill_write_q <= 1'b0;
    end else begin
      if (cancel_i && ap_valid_i) begin
        kill_pend_q  <= 1'b1;
        kill_write_q <= ap_write_i;
      end
      if (done) begin
        rsp_valid_o <= 1'b1;
        rsp_err_o   <= hresp_i;
        rsp_write_o <= dp_write_i;
        if (!dp_write_i) rsp_rdata_o <= hrdata_i;
      end else if (kill_pend_q) begin
        // cancelled follower reported once the failing transfer has answered
        rsp_valid_o <= 1'b1;
        rsp_err_o   <= 1'b1;
        rsp_write_o <= kill_write_q;
        kill_pend_q <= 1'b0;
      end else begin
        rsp_valid_o <= 1'b0;
      end
    end
  end

  // R5
  rdata_on_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o && !rsp_write_o) |-> (rsp_rdata_o == $past(hrdata_i)));
  // R6
  rsp_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o) |-> $past(hready_i));
endmodule

// File: rtl/ahb_stall_mgr.sv
module ahb_stall_mgr
  import ahb_mgr_pkg::*;
#(
  parameter int         AW   = 32,
  parameter int         DW   = 32,
  parameter logic [3:0] PROT = 4'b0011
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [2:0]    req_size_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic          rsp_write_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] haddr_o,
  output logic [1:0]    htrans_o,
  output logic          hwrite_o,
  output logic [2:0]    hsize_o,
  output logic [2:0]    hburst_o,
  output logic [3:0]    hprot_o,
  output logic [DW-1:0] hwdata_o,
  input  logic          hready_i,
  input  logic          hresp_i,
  input  logic [DW-1:0] hrdata_i
);
  logic          ap_valid, ap_write, dp_valid, dp_write, cancel;
  logic [AW-1:0] ap_addr;
  logic [2:0]    ap_size;
  logic [DW-1:0] ap_wdata;

  // first cycle of a two-cycle error response
  assign cancel = dp_valid && hresp_i && !hready_i;

  ahb_mgr_addr_stage #(.AW(AW), .DW(DW)) i_addr (
    .clk_i, .rst_ni, .hready_i, .cancel_i(cancel),
    .req_valid_i, .req_addr_i, .req_size_i, .req_write_i, .req_wdata_i,
    .req_ready_o,
    .ap_valid_o(ap_valid), .ap_addr_o(ap_addr), .ap_size_o(ap_size),
    .ap_write_o(ap_write), .ap_wdata_o(ap_wdata)
  );

  ahb_mgr_data_stage #(.DW(DW)) i_data (
    .clk_i, .rst_ni, .hready_i,
    .ap_valid_i(ap_valid), .ap_write_i(ap_write), .ap_wdata_i(ap_wdata),
    .dp_valid_o(dp_valid), .dp_write_o(dp_write), .hwdata_o
  );

  ahb_mgr_resp_stage #(.DW(DW)) i_resp (
    .clk_i, .rst_ni, .hready_i, .hresp_i, .hrdata_i,
    .dp_valid_i(dp_valid), .dp_write_i(dp_write),
    .cancel_i(cancel), .ap_valid_i(ap_valid), .ap_write_i(ap_write),
    .rsp_valid_o, .rsp_err_o, .rsp_write_o, .rsp_rdata_o
  );

  assign haddr_o  = ap_addr;
  assign htrans_o = ap_valid ? HTRANS_NONSEQ : HTRANS_IDLE;
  assign hwrite_o = ap_write;
  assign hsize_o  = ap_size;
  assign hburst_o = HBURST_SINGLE;
  assign hprot_o  = PROT;

  // R3
  addr_ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hready_i && !hresp_i) |=> ($stable(haddr_o) && $stable(htrans_o)
                                 && $stable(hwrite_o) && $stable(hsize_o)));
  // R8
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_valid && hresp_i && !hready_i) |=> (htrans_o == HTRANS_IDLE));
  // R2
  ready_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == hready_i);
endmodule

// File: tb/test_ahb_stall_mgr.sv
module test_ahb_stall_mgr;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NCMD = 120;
  localparam logic [3:0] PROT = 4'b0011;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o, req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [2:0] req_size_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic rsp_valid_o, rsp_err_o, rsp_write_o;
  logic [DW-1:0] rsp_rdata_o, hwdata_o, hrdata_i = '0;
  logic [AW-1:0] haddr_o;
  logic [1:0] htrans_o;
  logic hwrite_o, hready_i = 1'b1, hresp_i = 1'b0;
  logic [2:0] hsize_o, hburst_o;
  logic [3:0] hprot_o;

  always #10 clk_i = ~clk_i;

  ahb_stall_mgr #(.AW(AW), .DW(DW), .PROT(PROT)) i_ahb_stall_mgr (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_size_i,
    .req_write_i, .req_wdata_i, .rsp_valid_o, .rsp_err_o, .rsp_write_o,
    .rsp_rdata_o, .haddr_o, .htrans_o, .hwrite_o, .hsize_o, .hburst_o,
    .hprot_o, .hwdata_o, .hready_i, .hresp_i, .hrdata_i
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] c_addr(int i); return AW'(((i * 5) % 16) * 4); endfunction
  function automatic logic c_wr(int i); return (i % 3) != 1; endfunction
  function automatic logic [2:0] c_size(int i); return (i % 2) ? 3'd2 : 3'd1; endfunction
  function automatic logic [DW-1:0] c_wdata(int i); return DW'(i) * 32'h0101_0101 ^ 32'hA500_0000; endfunction
  function automatic int wait_pat(int k); return (k % 5 < 2) ? 0 : ((k * 3 + k / 5) % 8); endfunction

  logic [DW-1:0] mem [16];
  bit exp_wr [256], exp_err [256], exp_zw [256];
  logic [DW-1:0] exp_rd [256];
  int wp = 0, rp = 0;

  initial begin
    int issued = 0, rsp_cnt = 0, cyc = 0, dp_cnt = 0;
    bit dp_act = 0, dp_wr = 0, dp_err = 0, dp_zw = 0;
    int dp_stage = 0, dp_wait = 0, dp_cmd = 0;
    bit ap_act = 0, acc_last = 0, first = 1;
    int ap_cmd = 0, acc_cmd = 0;
    bit prev_hready = 1, prev_errfirst = 0, cancel_pend = 0, cancel_wr = 0;
    bit due_now = 0, due_next, errfirst, hr, hs, rv, timeout = 0;
    logic [AW-1:0] p_addr; logic [1:0] p_trans; logic p_wr; logic [2:0] p_size;
    logic [DW-1:0] p_wdata, hd;
    int idx;

    for (int j = 0; j < 16; j++) mem[j] = DW'(j) * 32'h1111_1111;
    repeat (3) @(negedge clk_i);
    chk(htrans_o == 2'b00, "R1 htrans in reset", 64'(htrans_o), 0);
    chk(rsp_valid_o == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid_o), 0);
    rst_ni = 1'b1;

    while (rsp_cnt < NCMD) begin
      cyc++;
      if (cyc > 20000) begin timeout = 1; break; end
      // responses
      if (due_now) begin
        chk(rsp_valid_o == 1'b1, exp_zw[rp] ? "R7 zero-wait response" : "R6 response valid",
            64'(rsp_valid_o), 1);
        chk(rsp_write_o == exp_wr[rp], "R6 response direction", 64'(rsp_write_o), 64'(exp_wr[rp]));
        chk(rsp_err_o == exp_err[rp], "R8 response error flag", 64'(rsp_err_o), 64'(exp_err[rp]));
        if (!exp_err[rp] && !exp_wr[rp])
          chk(rsp_rdata_o == exp_rd[rp], "R5 read data", 64'(rsp_rdata_o), 64'(exp_rd[rp]));
        rp++; rsp_cnt++;
      end else begin
        chk(rsp_valid_o == 1'b0, "R6 spurious response", 64'(rsp_valid_o), 0);
      end
      // bus address / control
      if (!first && !prev_hready && !prev_errfirst) begin
        chk(haddr_o == p_addr, "R3 haddr hold", 64'(haddr_o), 64'(p_addr));
        chk(htrans_o == p_trans, "R3 htrans hold", 64'(htrans_o), 64'(p_trans));
        chk(hwrite_o == p_wr, "R3 hwrite hold", 64'(hwrite_o), 64'(p_wr));
        chk(hsize_o == p_size, "R3 hsize hold", 64'(hsize_o), 64'(p_size));
      end
      if (!first && !prev_hready)
        chk(hwdata_o == p_wdata, "R4 hwdata hold", 64'(hwdata_o), 64'(p_wdata));
      if (prev_errfirst)
        chk(htrans_o == 2'b00, "R8 idle after error", 64'(htrans_o), 0);
      if (!first && prev_hready) begin
        if (acc_last) begin
          chk(htrans_o == 2'b10, "R2 nonseq", 64'(htrans_o), 2);
          chk(haddr_o == c_addr(acc_cmd), "R2 haddr", 64'(haddr_o), 64'(c_addr(acc_cmd)));
          chk(hwrite_o == c_wr(acc_cmd), "R2 hwrite", 64'(hwrite_o), 64'(c_wr(acc_cmd)));
          chk(hsize_o == c_size(acc_cmd), "R2 hsize", 64'(hsize_o), 64'(c_size(acc_cmd)));
        end else begin
          chk(htrans_o == 2'b00, "R2 idle", 64'(htrans_o), 0);
        end
      end
      chk(hburst_o == 3'b000 && hprot_o == PROT, "R2 burst/prot",
          64'({hburst_o, hprot_o}), 64'({3'b000, PROT}));
      if (prev_hready) begin ap_act = acc_last; ap_cmd = acc_cmd; end
      else if (prev_errfirst) ap_act = 0;
      // subordinate model
      idx = dp_cmd;
      if (dp_act && dp_err) begin hr = (dp_stage == 1); hs = 1; hd = ~mem[c_addr(idx)[5:2]]; end
      else if (dp_act && dp_wait > 0) begin hr = 0; hs = 0; hd = ~mem[c_addr(idx)[5:2]]; end
      else if (dp_act) begin hr = 1; hs = 0; hd = mem[c_addr(idx)[5:2]]; end
      else begin hr = 1; hs = 0; hd = 32'hBAD0_0000 | DW'(cyc); end
      hready_i = hr; hresp_i = hs; hrdata_i = hd;
      // requester
      rv = (issued < NCMD) && (cyc % 7 != 3);
      req_valid_i = rv;
      req_addr_i = c_addr(issued); req_write_i = c_wr(issued);
      req_size_i = c_size(issued); req_wdata_i = c_wdata(issued);
      #1;
      chk(req_ready_o == hr, "R2 ready follows hready", 64'(req_ready_o), 64'(hr));
      // next state
      errfirst = dp_act && dp_err && dp_stage == 0;
      due_next = 0;
      if (hr) begin
        if (dp_act) begin
          if (dp_wr && !dp_err) begin
            chk(hwdata_o == c_wdata(dp_cmd), "R4 hwdata value", 64'(hwdata_o), 64'(c_wdata(dp_cmd)));
            mem[c_addr(dp_cmd)[5:2]] = hwdata_o;
          end
          exp_wr[wp] = dp_wr; exp_err[wp] = dp_err; exp_zw[wp] = dp_zw; exp_rd[wp] = hd;
          wp++; due_next = 1;
        end
        dp_act = ap_act;
        if (ap_act) begin
          dp_cmd = ap_cmd; dp_wr = c_wr(ap_cmd);
          dp_err = (dp_cnt % 17 == 9);
          dp_wait = dp_err ? 0 : wait_pat(dp_cnt);
          dp_zw = !dp_err && dp_wait == 0;
          dp_stage = 0; dp_cnt++;
        end
        acc_last = rv; acc_cmd = issued;
        if (rv) issued++;
      end else begin
        if (dp_act && dp_err) dp_stage = 1;
        else if (dp_act) dp_wait--;
        acc_last = 0;
      end
      if (!due_next && cancel_pend) begin
        exp_wr[wp] = cancel_wr; exp_err[wp] = 1; exp_zw[wp] = 0; exp_rd[wp] = '0;
        wp++; due_next = 1; cancel_pend = 0;
      end
      if (errfirst && ap_act) begin cancel_pend = 1; cancel_wr = c_wr(ap_cmd); end
      prev_hready = hr; prev_errfirst = errfirst; first = 0;
      p_addr = haddr_o; p_trans = htrans_o; p_wr = hwrite_o; p_size = hsize_o; p_wdata = hwdata_o;
      due_now = due_next;
      @(negedge clk_i);
    end

    if (timeout) chk(1'b0, "R6 watchdog expired", 64'(rsp_cnt), 64'(NCMD));
    chk(issued == NCMD, "R6 all commands issued", 64'(issued), 64'(NCMD));
    req_valid_i = 1'b0; hready_i = 1'b1; hresp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(htrans_o == 2'b00, "R2 idle when drained", 64'(htrans_o), 0);
    chk(rsp_valid_o == 1'b0, "R6 no extra response", 64'(rsp_valid_o), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule